// File: doc/BRIEF.md
# Save-RAM Byte-Lane Adapter

This block connects a 16-bit big-endian processor bus to a byte-wide save memory. The save memory can be wired across both byte lanes, to the upper (even-address) lane only, or to the lower (odd-address) lane only. The adapter accepts one byte or word access at a time. It keeps only the address bits that fall inside the mapped window, which is the same as ANDing the address with a power-of-two mask. It then turns the bus address into memory indices for the selected wiring, drives the correct data lane, and fills any lane with no memory behind it with all ones.

A request is taken when `req_valid` and `req_ready` are both high. A four-state sequencer then carries the access:

- `ST_IDLE` moves to `ST_FIRST` on acceptance.
- `ST_FIRST` performs the first memory beat. It moves to `ST_SECOND` when a word access in both-lane mode needs a second byte, and to `ST_DONE` otherwise.
- `ST_SECOND` performs the second beat and moves to `ST_DONE`.
- `ST_DONE` raises `rsp_valid` for one cycle and returns to `ST_IDLE`.

Writes are gated by a two-bit control value that must equal binary 01 when the request is accepted. Memory contents are not initialised by reset.

Top module: `save_lane_adapter`

## Requirements
- R1: Only the low MAP_AW bits of `req_addr` are used. Two addresses that differ only above bit MAP_AW-1 reach the same memory byte.
- R2: With `lane_mode`=00 (both lanes), a word access at masked address a uses index a for bits 15:8 and index a+1 (modulo 2^MAP_AW) for bits 7:0, for both reads and writes.
- R3: With `lane_mode`=01 (upper lane only), a word read returns the byte at index a>>1 in bits 15:8 and 8'hFF in bits 7:0. A word write stores only `req_wdata[15:8]`, at index a>>1.
- R4: With `lane_mode`=10 (lower lane only), a word read returns 8'hFF in bits 15:8 and the byte at index a>>1 in bits 7:0. A word write stores only `req_wdata[7:0]`, at index a>>1.
- R5: A byte read returns its byte in `rsp_rdata[7:0]`, with bits 15:8 at 8'hFF. In both-lane mode the byte comes from index a. In a single-lane mode it comes from index a>>1 when the address parity matches the wired lane (even for upper, odd for lower); otherwise the read returns 8'hFF. In a single-lane mode, no index at or above 2^(MAP_AW-1) is ever touched.
- R6: A byte write stores `req_wdata[7:0]`. In both-lane mode it goes to index a. In a single-lane mode it goes to index a>>1 when the parity matches the wired lane, and it is ignored otherwise.
- R7: A write changes memory only if `wr_ctl` equals 2'b01 in the cycle the request is accepted.
- R8: With `lane_mode`=11, reads return 16'hFFFF and writes leave memory unchanged.
- R9: `req_ready` is high only in `ST_IDLE`. `rsp_valid` pulses for exactly one cycle per request. It pulses two clock edges after acceptance, or three for a both-lane word access.
- R10: After reset the block is in `ST_IDLE`, with `req_ready`=1, `rsp_valid`=0 and `rsp_rdata`=16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | BUS_AW | Bus byte address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| lane_mode | input | 2 | 00 both lanes, 01 upper only, 10 lower only, 11 invalid |
| wr_ctl | input | 2 | Write key; writes are allowed when it equals 01 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, valid with `rsp_valid` |

## Verification
The embedded assertions check four things on every cycle: no memory write happens without the write key or in the invalid mode, single-lane modes never reach the upper half of the memory, and a lane mismatch on a byte write never writes. They also check that the second beat occurs only for both-lane words and that acceptance and completion behave as one-cycle handshakes. Data-level behaviour can only be shown by the bench's scenarios, which drive requests and read back through the bus port. This covers byte ordering across lanes, the 8'hFF fill on unwired lanes, address aliasing, wrap of the second word byte, and the fact that ignored writes leave memory untouched.

// File: rtl/lane_pkg.sv
package lane_pkg;

    typedef enum logic [1:0] {
        LM_BOTH = 2'b00,
        LM_EVEN = 2'b01,
        LM_ODD  = 2'b10,
        LM_BAD  = 2'b11
    } lane_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_DONE
    } seq_state_e;

    // One memory beat: whether it touches memory and which bus byte it maps to
    typedef struct packed {
        logic active;
        logic hi_byte;
    } beat_t;

    localparam logic [1:0] WR_KEY = 2'b01;

endpackage

// File: rtl/lane_decode.sv
module lane_decode
    import lane_pkg::*;
#(
    parameter int MAP_AW = 11
) (
    input  lane_mode_e         mode,
    input  logic               word,
    input  logic [MAP_AW-1:0]  addr,
    output beat_t              beat0,
    output beat_t              beat1,
    output logic [MAP_AW-1:0]  idx0,
    output logic [MAP_AW-1:0]  idx1,
    output logic               two_beats
);

    localparam logic [MAP_AW-1:0] ONE = {{(MAP_AW-1){1'b0}}, 1'b1};

    logic [MAP_AW-1:0] half_idx;
    assign half_idx = {1'b0, addr[MAP_AW-1:1]};

    always_comb begin
        beat0     = '{active: 1'b0, hi_byte: 1'b0};
        beat1     = '{active: 1'b0, hi_byte: 1'b0};
        idx0      = addr;
        idx1      = addr + ONE;
        two_beats = 1'b0;
        unique case (mode)
            LM_BOTH: begin
                idx0 = addr;
                if (word) begin
                    beat0     = '{active: 1'b1, hi_byte: 1'b1};
                    beat1     = '{active: 1'b1, hi_byte: 1'b0};
                    two_beats = 1'b1;
                end else begin
                    beat0 = '{active: 1'b1, hi_byte: 1'b0};
                end
            end
            LM_EVEN: begin
                idx0 = half_idx;
                if (word) beat0 = '{active: 1'b1,     hi_byte: 1'b1};
                else      beat0 = '{active: !addr[0], hi_byte: 1'b0};
            end
            LM_ODD: begin
                idx0 = half_idx;
                if (word) beat0 = '{active: 1'b1,    hi_byte: 1'b0};
                else      beat0 = '{active: addr[0], hi_byte: 1'b0};
            end
            LM_BAD: begin
                idx0 = addr;
            end
        endcase
    end

endmodule

// File: rtl/lane_seq.sv
module lane_seq
    import lane_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic two_beats,
    output logic req_ready,
    output logic accept,
    output logic in_first,
    output logic in_second,
    output logic rsp_valid
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_FIRST;
            ST_FIRST:  state_d = two_beats ? ST_SECOND : ST_DONE;
            ST_SECOND: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_ready && req_valid;
        in_first  = (state_q == ST_FIRST);
        in_second = (state_q == ST_SECOND);
        rsp_valid = (state_q == ST_DONE);
    end

    AST_SECOND_IS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        in_second |-> two_beats); // R2
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready); // R9

endmodule

// File: rtl/lane_byte_ram.sv
module lane_byte_ram #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/save_lane_adapter.sv
module save_lane_adapter
    import lane_pkg::*;
#(
    parameter int BUS_AW = 24,
    parameter int MAP_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [BUS_AW-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        lane_mode,
    input  logic [1:0]        wr_ctl,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata
);

    localparam logic [BUS_AW-1:0] ADDR_MASK = BUS_AW'((64'd1 << MAP_AW) - 64'd1);

    logic [BUS_AW-1:0] masked_addr;
    logic              unused_hi;
    assign masked_addr = req_addr & ADDR_MASK;
    assign unused_hi   = |masked_addr[BUS_AW-1:MAP_AW];

    // Request captured at acceptance
    logic [MAP_AW-1:0] addr_q;
    logic              write_q, word_q, wen_q;
    logic [15:0]       wdata_q, rd_q;
    lane_mode_e        mode_q;

    logic accept, in_first, in_second, two_beats;
    beat_t             beat0, beat1, beat_cur;
    logic [MAP_AW-1:0] idx0, idx1, ram_idx;
    logic              ram_we, beat_live;
    logic [7:0]        ram_wdata, ram_rdata;

    lane_decode #(.MAP_AW(MAP_AW)) u_decode (
        .mode      (mode_q),
        .word      (word_q),
        .addr      (addr_q),
        .beat0     (beat0),
        .beat1     (beat1),
        .idx0      (idx0),
        .idx1      (idx1),
        .two_beats (two_beats)
    );

    lane_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .two_beats (two_beats),
        .req_ready (req_ready),
        .accept    (accept),
        .in_first  (in_first),
        .in_second (in_second),
        .rsp_valid (rsp_valid)
    );

    always_comb begin
        beat_cur  = in_second ? beat1 : beat0;
        ram_idx   = in_second ? idx1  : idx0;
        beat_live = (in_first || in_second) && beat_cur.active;
        ram_we    = beat_live && write_q && wen_q;
        ram_wdata = beat_cur.hi_byte ? wdata_q[15:8] : wdata_q[7:0];
    end

    lane_byte_ram #(.AW(MAP_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (ram_idx),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            word_q  <= 1'b0;
            wen_q   <= 1'b0;
            wdata_q <= '0;
            mode_q  <= LM_BAD;
            rd_q    <= 16'hFFFF;
        end else if (accept) begin
            addr_q  <= masked_addr[MAP_AW-1:0];
            write_q <= req_write;
            word_q  <= req_word;
            wen_q   <= (wr_ctl == WR_KEY);
            wdata_q <= req_wdata;
            mode_q  <= lane_mode_e'(lane_mode);
            rd_q    <= 16'hFFFF;
        end else if (beat_live && !write_q) begin
            if (beat_cur.hi_byte) rd_q[15:8] <= ram_rdata;
            else                  rd_q[7:0]  <= ram_rdata;
        end
    end

    assign rsp_rdata = rd_q;

    AST_WRITE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> wen_q); // R7
    AST_BAD_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (mode_q != LM_BAD)); // R8
    AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_live && mode_q != LM_BOTH) |-> !ram_idx[MAP_AW-1]); // R5
    AST_EVEN_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !word_q && mode_q == LM_EVEN) |-> !addr_q[0]); // R6
    AST_ODD_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !word_q && mode_q == LM_ODD) |-> addr_q[0]); // R6

endmodule

// File: tb/save_lane_adapter_bench.sv
module save_lane_adapter_bench;

    localparam int BUS_AW = 24;
    localparam int MAP_AW = 11;
    localparam int SPAN   = 1 << MAP_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  lane_mode = 2'b00;
    logic [1:0]  wr_ctl = 2'b00;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    save_lane_adapter #(.BUS_AW(BUS_AW), .MAP_AW(MAP_AW)) u_save_lane_adapter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
        .req_wdata(req_wdata), .lane_mode(lane_mode), .wr_ctl(wr_ctl),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // Behavioural reference: memory image and cycles remaining in a transaction
    logic [7:0] m_mem [SPAN];
    int m_left = 0;

    always @(posedge clk) begin
        if (!rst_n) m_left = 0;
        else if (m_left == 0) begin
            if (req_valid) m_left = (lane_mode == 2'b00 && req_word) ? 3 : 2;
        end else m_left = m_left - 1;
    end

    // R9: handshake compared on every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            tests++;
            if (req_ready !== (m_left == 0) || rsp_valid !== (m_left == 1)) begin
                fails++;
                $display("FAIL R9 ready=%b rsp=%b expected ready=%b rsp=%b",
                         req_ready, rsp_valid, (m_left == 0), (m_left == 1));
            end
        end
    end

    task automatic do_op(input logic wr, input logic wd, input logic [23:0] addr,
                         input logic [15:0] data, input logic [1:0] mode,
                         input logic [1:0] ctl, input string tag);
        int a, h;
        logic [15:0] exp;
        logic ok;
        a   = int'(addr) % SPAN;
        h   = a >> 1;
        ok  = wr && (ctl == 2'b01);
        exp = 16'hFFFF;
        case (mode)
            2'b00: if (wd) begin
                       exp = {m_mem[a], m_mem[(a + 1) % SPAN]};
                       if (ok) begin m_mem[a] = data[15:8]; m_mem[(a + 1) % SPAN] = data[7:0]; end
                   end else begin
                       exp = {8'hFF, m_mem[a]};
                       if (ok) m_mem[a] = data[7:0];
                   end
            2'b01: if (wd) begin
                       exp = {m_mem[h], 8'hFF};
                       if (ok) m_mem[h] = data[15:8];
                   end else if (a % 2 == 0) begin
                       exp = {8'hFF, m_mem[h]};
                       if (ok) m_mem[h] = data[7:0];
                   end
            2'b10: if (wd) begin
                       exp = {8'hFF, m_mem[h]};
                       if (ok) m_mem[h] = data[7:0];
                   end else if (a % 2 == 1) begin
                       exp = {8'hFF, m_mem[h]};
                       if (ok) m_mem[h] = data[7:0];
                   end
            default: exp = 16'hFFFF;
        endcase
        req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = addr;
        req_wdata = data; lane_mode = mode; wr_ctl = ctl;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        if (!wr) begin
            tests++;
            if (rsp_rdata !== exp) begin
                fails++;
                $display("FAIL %s addr=%h mode=%b rdata=%h expected %h", tag, addr, mode, rsp_rdata, exp);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < SPAN; i++) m_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R10: reset state
        tests++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || rsp_rdata !== 16'hFFFF) begin
            fails++;
            $display("FAIL R10 ready=%b rsp=%b rdata=%h expected 1 0 ffff", req_ready, rsp_valid, rsp_rdata);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // clear memory through the bus
        for (int i = 0; i < SPAN; i += 2) do_op(1, 1, 24'(i), 16'h0000, 2'b00, 2'b01, "init");

        // R2: word order and wrap of the second byte
        do_op(1, 1, 24'h000010, 16'h1234, 2'b00, 2'b01, "R2");
        do_op(0, 1, 24'h000010, 16'h0,    2'b00, 2'b01, "R2");
        do_op(0, 0, 24'h000011, 16'h0,    2'b00, 2'b01, "R2");
        do_op(1, 1, 24'h0007FF, 16'hABCD, 2'b00, 2'b01, "R2");
        do_op(0, 0, 24'h000000, 16'h0,    2'b00, 2'b01, "R2");
        do_op(0, 1, 24'h0007FF, 16'h0,    2'b00, 2'b01, "R2");
        // R1: aliasing above the mapped window
        do_op(0, 1, 24'h120810, 16'h0,    2'b00, 2'b01, "R1");
        do_op(1, 0, 24'hFFF812, 16'h00EE, 2'b00, 2'b01, "R1");
        do_op(0, 0, 24'h000012, 16'h0,    2'b00, 2'b01, "R1");
        // R3: upper lane only, the low byte is not stored
        do_op(1, 1, 24'h000020, 16'h5566, 2'b01, 2'b01, "R3");
        do_op(0, 1, 24'h000020, 16'h0,    2'b01, 2'b01, "R3");
        do_op(0, 0, 24'h000010, 16'h0,    2'b00, 2'b01, "R3");
        do_op(0, 0, 24'h000011, 16'h0,    2'b00, 2'b01, "R3");
        // R4: lower lane only
        do_op(1, 1, 24'h000040, 16'h7788, 2'b10, 2'b01, "R4");
        do_op(0, 1, 24'h000040, 16'h0,    2'b10, 2'b01, "R4");
        do_op(0, 0, 24'h000020, 16'h0,    2'b00, 2'b01, "R4");
        // R5: byte reads on wired and unwired lanes
        do_op(0, 0, 24'h000021, 16'h0,    2'b01, 2'b01, "R5");
        do_op(0, 0, 24'h000020, 16'h0,    2'b01, 2'b01, "R5");
        do_op(0, 0, 24'h000040, 16'h0,    2'b10, 2'b01, "R5");
        do_op(0, 0, 24'h000041, 16'h0,    2'b10, 2'b01, "R5");
        // R6: byte writes, unwired lane ignored
        do_op(1, 0, 24'h000023, 16'h0099, 2'b01, 2'b01, "R6");
        do_op(0, 0, 24'h000011, 16'h0,    2'b00, 2'b01, "R6");
        do_op(1, 0, 24'h000022, 16'h0042, 2'b01, 2'b01, "R6");
        do_op(0, 0, 24'h000011, 16'h0,    2'b00, 2'b01, "R6");
        do_op(1, 0, 24'h000044, 16'h0061, 2'b10, 2'b01, "R6");
        do_op(1, 0, 24'h000045, 16'h0017, 2'b10, 2'b01, "R6");
        do_op(0, 1, 24'h000044, 16'h0,    2'b00, 2'b01, "R6");
        // R7: write key other than 01 blocks writes
        do_op(1, 1, 24'h000010, 16'hDEAD, 2'b00, 2'b00, "R7");
        do_op(1, 1, 24'h000010, 16'hBEEF, 2'b00, 2'b11, "R7");
        do_op(1, 1, 24'h000010, 16'hF00D, 2'b00, 2'b10, "R7");
        do_op(0, 1, 24'h000010, 16'h0,    2'b00, 2'b00, "R7");
        // R8: invalid mode
        do_op(0, 1, 24'h000010, 16'h0,    2'b11, 2'b01, "R8");
        do_op(0, 0, 24'h000011, 16'h0,    2'b11, 2'b01, "R8");
        do_op(1, 1, 24'h000010, 16'hC0DE, 2'b11, 2'b01, "R8");
        do_op(0, 1, 24'h000010, 16'h0,    2'b00, 2'b01, "R8");
        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            do_op(1'($urandom), 1'($urandom), 24'($urandom), 16'($urandom),
                  2'($urandom), ($urandom % 3 == 0) ? 2'($urandom) : 2'b01, "R9");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule